// File: doc/BRIEF.md
# Multi-channel down-counting interval timer

This block is a bank of independent down-counters behind a word-addressed register port. Each channel holds a control word, an interval (reload) value and a live count. Once started, a channel moves its count down by one on every step. Steps come from a shared tick input, passed through a per-channel prescaler that divides by 1 to 8.

A step that finds the count already at zero is an expiry. An expiry sets the channel's pending flag. What happens next depends on the mode:
- In single-shot mode the channel stops.
- In continuous mode with reload, the count restarts from the interval value.
- In continuous mode without reload, the count wraps around and keeps running.

A shared enable word masks the pending flags. The masked flags are ORed onto one interrupt line. Software clears a pending flag by writing a one to its bit.

Software programs a channel in this order: write the interval and the starting count, then set the run bit in the control word. It services the interrupt by reading the status word and writing back the bits it has handled. The two-bit source field of the control word is stored and read back only. Every channel counts the same tick input.

Top module: `intv_timer_bank`

## Requirements
- R1: After a synchronous reset every register reads zero and `irq` is low.
- R2: Word addresses follow this map:
  - word 0: enable;
  - word 1: status;
  - channel n: control at word 4+4n, interval at word 5+4n, current count at word 6+4n.
  
  Control bits:
  - bit 0: run;
  - bit 1: reload;
  - bits 3:2: source, stored only;
  - bits 6:4: divisor minus one;
  - bit 7: single-shot.
  
  Control bits above 7, and every unmapped word, read zero.
- R3: The current count is writable at any time. While the run bit is clear, the count holds its value and ticks have no effect on it.
- R4: A running channel takes one step for every (divisor minus one, plus 1) tick cycles. A control write restarts the prescaler phase.
- R5: A step taken while the count is zero is an expiry and sets the channel's status bit. A channel started at N expires on its (N+1)-th step.
- R6: In single-shot mode (bit 7 = 1), an expiry clears the run bit and the count stays at zero, whatever the reload bit holds.
- R7: In continuous mode (bit 7 = 0) with reload set, an expiry loads the interval value and counting continues. The period is interval+1 steps.
- R8: In continuous mode without reload, an expiry wraps the count to all ones and counting continues.
- R9: Writing status clears each bit written as one and leaves the bits written as zero. An expiry in the same cycle as a clear of that bit leaves it set.
- R10: `irq` is the OR over channels of status AND enable. It follows register state with no extra delay.
- R11: Channels are independent: a write to, or an expiry of, one channel changes no other channel's registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Shared count tick, one cycle per tick |
| wr_en | input | 1 | Register write strobe |
| addr | input | AW (6) | Word address for read and write |
| wdata | input | DW (32) | Write data |
| rd_data | output | DW (32) | Read data for `addr`, combinational |
| irq | output | 1 | Combined masked interrupt |

## Verification
The bench goes after the following corner cases:
- **Off-by-one at expiry.** A design that expires on reaching zero rather than on the step after it would show the wrong count and an early pending bit.
- **Single-shot mode with reload also set.** A design that lets reload win would keep running instead of parking at zero with the run bit cleared.
- **Free-running wrap.** A design that stops or reloads here would not read all ones.
- **Clear racing an expiry.** A design that gives the clear priority would lose an interrupt.

Random reload runs across all prescaler settings catch a divisor miscount. Address-map sweeps catch a wrong stride or leaking upper control bits.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int WORD_ENABLE = 0;
    localparam int WORD_STATUS = 1;
    localparam int CH_BASE     = 4;
    localparam int CH_STRIDE   = 4;

    typedef enum logic [1:0] {
        REG_CTRL = 2'd0,
        REG_INTV = 2'd1,
        REG_CUR  = 2'd2,
        REG_NONE = 2'd3
    } chreg_e;

    // control word, bit 7 down to bit 0
    typedef struct packed {
        logic       single;
        logic [2:0] div_m1;
        logic [1:0] src;
        logic       reload;
        logic       run;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    typedef struct packed {
        logic       hit;
        logic [7:0] ch;
        chreg_e     kind;
    } dec_t;

    function automatic dec_t decode(input logic [15:0] a, input int nch);
        dec_t        d;
        logic [15:0] off;
        off    = a - 16'(CH_BASE);
        d.hit  = (a >= 16'(CH_BASE)) && (a < 16'(CH_BASE + CH_STRIDE * nch))
                 && (off[1:0] != 2'd3);
        d.ch   = off[9:2];
        d.kind = chreg_e'(off[1:0]);
        return d;
    endfunction

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int DIVW = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            tick,
    input  logic            run,
    input  logic            restart,
    input  logic [DIVW-1:0] div_m1,
    output logic            step
);
    logic [DIVW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run || restart)
            cnt <= '0;
        else if (tick)
            cnt <= (cnt == div_m1) ? '0 : cnt + 1'b1;
    end

    assign step = run && tick && (cnt == div_m1);
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          ctrl_we,
    input  logic          intv_we,
    input  logic          cur_we,
    input  logic [DW-1:0] wdata,
    output ctrl_t         ctrl_o,
    output logic [DW-1:0] intv_o,
    output logic [DW-1:0] cur_o,
    output logic          expire_o
);
    ctrl_t         ctrl_q;
    logic [DW-1:0] intv_q, cur_q, cur_nx;
    logic          step, expire;

    tmr_prescaler #(.DIVW(3)) u_pre (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick),
        .run    (ctrl_q.run),
        .restart(ctrl_we),
        .div_m1 (ctrl_q.div_m1),
        .step   (step)
    );

    assign expire = step && (cur_q == '0);

    always_comb begin
        if (!expire)          cur_nx = cur_q - 1'b1;
        else if (ctrl_q.single) cur_nx = '0;
        else if (ctrl_q.reload) cur_nx = intv_q;
        else                  cur_nx = cur_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)                          ctrl_q <= '0;
        else if (ctrl_we)                 ctrl_q <= ctrl_t'(wdata[CTRL_W-1:0]);
        else if (expire && ctrl_q.single) ctrl_q.run <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst)          intv_q <= '0;
        else if (intv_we) intv_q <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst)         cur_q <= '0;
        else if (cur_we) cur_q <= wdata;
        else if (step)   cur_q <= cur_nx;
    end

    assign ctrl_o   = ctrl_q;
    assign intv_o   = intv_q;
    assign cur_o    = cur_q;
    assign expire_o = expire;
endmodule

// File: rtl/tmr_irq_ctrl.sv
module tmr_irq_ctrl #(
    parameter int NCH = 6
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           en_we,
    input  logic           st_we,
    input  logic [NCH-1:0] wdata,
    input  logic [NCH-1:0] expire,
    output logic [NCH-1:0] en_o,
    output logic [NCH-1:0] st_o,
    output logic           irq_o
);
    logic [NCH-1:0] en_q, st_q, clr;

    assign clr = st_we ? wdata : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= '0;
            st_q <= '0;
        end else begin
            if (en_we) en_q <= wdata;
            st_q <= (st_q & ~clr) | expire;
        end
    end

    assign en_o  = en_q;
    assign st_o  = st_q;
    assign irq_o = |(st_q & en_q);
endmodule

// File: rtl/intv_timer_bank.sv
module intv_timer_bank
    import tmr_pkg::*;
#(
    parameter int NCH = 6,
    parameter int DW  = 32,
    parameter int AW  = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rd_data,
    output logic          irq
);
    dec_t           dec;
    ctrl_t          ctrl_q [NCH];
    logic [DW-1:0]  intv_q [NCH];
    logic [DW-1:0]  cur_q  [NCH];
    logic [NCH-1:0] ctrl_we, intv_we, cur_we, expire;
    logic [NCH-1:0] en_q, st_q;
    logic           en_we, st_we;

    assign dec   = decode(16'(addr), NCH);
    assign en_we = wr_en && (addr == AW'(WORD_ENABLE));
    assign st_we = wr_en && (addr == AW'(WORD_STATUS));

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        logic sel;
        assign sel        = wr_en && dec.hit && (dec.ch == 8'(g));
        assign ctrl_we[g] = sel && (dec.kind == REG_CTRL);
        assign intv_we[g] = sel && (dec.kind == REG_INTV);
        assign cur_we[g]  = sel && (dec.kind == REG_CUR);

        tmr_channel #(.DW(DW)) u_ch (
            .clk     (clk),
            .rst     (rst),
            .tick    (tick),
            .ctrl_we (ctrl_we[g]),
            .intv_we (intv_we[g]),
            .cur_we  (cur_we[g]),
            .wdata   (wdata),
            .ctrl_o  (ctrl_q[g]),
            .intv_o  (intv_q[g]),
            .cur_o   (cur_q[g]),
            .expire_o(expire[g])
        );
    end

    tmr_irq_ctrl #(.NCH(NCH)) u_irq (
        .clk   (clk),
        .rst   (rst),
        .en_we (en_we),
        .st_we (st_we),
        .wdata (wdata[NCH-1:0]),
        .expire(expire),
        .en_o  (en_q),
        .st_o  (st_q),
        .irq_o (irq)
    );

    always_comb begin
        rd_data = '0;
        if (addr == AW'(WORD_ENABLE)) rd_data = DW'(en_q);
        if (addr == AW'(WORD_STATUS)) rd_data = DW'(st_q);
        for (int i = 0; i < NCH; i++) begin
            if (dec.hit && dec.ch == 8'(i)) begin
                case (dec.kind)
                    REG_CTRL: rd_data = DW'(ctrl_q[i]);
                    REG_INTV: rd_data = intv_q[i];
                    REG_CUR:  rd_data = cur_q[i];
                    default:  rd_data = '0;
                endcase
            end
        end
    end
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
    parameter int NCH = 6,
    parameter int DW  = 32
) (
    input logic           clk,
    input logic           rst,
    input tmr_pkg::ctrl_t ctrl_q [NCH],
    input logic [DW-1:0]  intv_q [NCH],
    input logic [DW-1:0]  cur_q  [NCH],
    input logic [NCH-1:0] ctrl_we,
    input logic [NCH-1:0] cur_we,
    input logic [NCH-1:0] expire,
    input logic [NCH-1:0] st_q,
    input logic [NCH-1:0] en_q,
    input logic           irq
);
    for (genvar g = 0; g < NCH; g++) begin : g_chk
        assert_freeze_R3: assert property (@(posedge clk) disable iff (rst)
            (!ctrl_q[g].run && !cur_we[g]) |=> $stable(cur_q[g]));

        assert_pending_R5: assert property (@(posedge clk) disable iff (rst)
            expire[g] |=> st_q[g]);

        assert_single_stop_R6: assert property (@(posedge clk) disable iff (rst)
            (expire[g] && ctrl_q[g].single && !ctrl_we[g] && !cur_we[g])
            |=> (!ctrl_q[g].run && cur_q[g] == '0));

        assert_reload_R7: assert property (@(posedge clk) disable iff (rst)
            (expire[g] && !ctrl_q[g].single && ctrl_q[g].reload && !cur_we[g])
            |=> (cur_q[g] == $past(intv_q[g])));

        assert_wrap_R8: assert property (@(posedge clk) disable iff (rst)
            (expire[g] && !ctrl_q[g].single && !ctrl_q[g].reload && !cur_we[g])
            |=> (cur_q[g] == '1));
    end

    assert_masked_R10: assert property (@(posedge clk) disable iff (rst)
        (en_q == '0) |-> !irq);
endmodule

bind intv_timer_bank tmr_checker #(.NCH(NCH), .DW(DW)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .ctrl_q (ctrl_q),
    .intv_q (intv_q),
    .cur_q  (cur_q),
    .ctrl_we(ctrl_we),
    .cur_we (cur_we),
    .expire (expire),
    .st_q   (st_q),
    .en_q   (en_q),
    .irq    (irq)
);

// File: tb/sim_intv_timer_bank.sv
module sim_intv_timer_bank;
    localparam int NCH = 6;
    localparam int DW  = 32;
    localparam int AW  = 6;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          tick = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rd_data;
    logic          irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    intv_timer_bank #(.NCH(NCH), .DW(DW), .AW(AW)) u0 (
        .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rd_data(rd_data), .irq(irq)
    );

    function automatic int a_ctrl(input int ch); return 4 + 4 * ch; endfunction
    function automatic int a_intv(input int ch); return 5 + 4 * ch; endfunction
    function automatic int a_cur (input int ch); return 6 + 4 * ch; endfunction

    function automatic logic [31:0] mk_ctrl(input bit single, input int div_m1,
                                            input bit reload, input bit run);
        return {24'd0, single, 3'(div_m1), 2'b00, reload, run};
    endfunction

    // expected count after s steps in reload mode, start N, interval I
    function automatic logic [31:0] exp_reload(input int n, input int iv, input int s);
        if (s <= n) return 32'(n - s);
        return 32'(iv - ((s - n - 1) % (iv + 1)));
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = AW'(a); wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        @(negedge clk);
        addr = AW'(a);
        #1;
        d = rd_data;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tick = 1'b1;
        end
        @(negedge clk);
        tick = 1'b0;
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(0, v); chk("R1 enable", v, 0);
        rd(1, v); chk("R1 status", v, 0);
        for (int c = 0; c < NCH; c++) begin
            rd(a_ctrl(c), v); chk("R1 ctrl", v, 0);
            rd(a_intv(c), v); chk("R1 intv", v, 0);
            rd(a_cur(c), v);  chk("R1 cur", v, 0);
        end
        #1; chk("R1 irq", 32'(irq), 0);

        // R2 address map and readback
        for (int c = 0; c < NCH; c++) begin
            wr(a_intv(c), 32'hA500_0000 | 32'(c));
            wr(a_cur(c),  32'h1234_0000 | 32'(c << 4));
            wr(a_ctrl(c), 32'hFFFF_FF7C);
        end
        for (int c = 0; c < NCH; c++) begin
            rd(a_intv(c), v); chk("R2 intv map", v, 32'hA500_0000 | 32'(c));
            rd(a_cur(c), v);  chk("R2 cur map", v, 32'h1234_0000 | 32'(c << 4));
            rd(a_ctrl(c), v); chk("R2 ctrl upper bits zero", v, 32'h7C);
            rd(a_ctrl(c) + 3, v); chk("R2 unmapped pad", v, 0);
        end
        rd(2, v); chk("R2 unmapped word 2", v, 0);
        rd(4 + 4 * NCH, v); chk("R2 beyond last channel", v, 0);
        for (int c = 0; c < NCH; c++) wr(a_ctrl(c), 0);

        // R3 stopped channel holds
        wr(a_cur(1), 10);
        ticks(20);
        rd(a_cur(1), v); chk("R3 frozen while stopped", v, 10);

        // R4 prescaler divide by 4
        wr(a_cur(1), 100);
        wr(a_ctrl(1), mk_ctrl(0, 3, 0, 1));
        ticks(13);
        wr(a_ctrl(1), 0);
        rd(a_cur(1), v); chk("R4 divide by 4", v, 97);
        // R3 count held after stop
        ticks(8);
        rd(a_cur(1), v); chk("R3 hold after stop", v, 97);

        // R5/R6 single-shot with reload also set
        wr(1, 32'h3F);
        wr(a_intv(2), 50);
        wr(a_cur(2), 3);
        wr(a_ctrl(2), mk_ctrl(1, 0, 1, 1));
        ticks(3);
        rd(a_cur(2), v); chk("R5 reached zero", v, 0);
        rd(1, v); chk("R5 no expiry yet", v & 32'h4, 0);
        ticks(1);
        rd(1, v); chk("R5 pending on step at zero", v & 32'h4, 32'h4);
        rd(a_ctrl(2), v); chk("R6 run bit cleared", v, 32'h82);
        ticks(5);
        rd(a_cur(2), v); chk("R6 parked at zero", v, 0);

        // R7 continuous reload
        wr(a_intv(3), 4);
        wr(a_cur(3), 2);
        wr(a_ctrl(3), mk_ctrl(0, 0, 1, 1));
        ticks(3);
        rd(a_cur(3), v); chk("R7 reload after expiry", v, 4);
        rd(1, v); chk("R7 pending", v & 32'h8, 32'h8);
        ticks(5);
        rd(a_cur(3), v); chk("R7 second period", v, 4);
        wr(a_ctrl(3), 0);

        // R8 free-running wrap
        wr(a_cur(4), 1);
        wr(a_ctrl(4), mk_ctrl(0, 0, 0, 1));
        ticks(2);
        rd(a_cur(4), v); chk("R8 wrap to all ones", v, 32'hFFFF_FFFF);
        rd(1, v); chk("R8 pending", v & 32'h10, 32'h10);
        ticks(1);
        wr(a_ctrl(4), 0);
        rd(a_cur(4), v); chk("R8 keeps counting", v, 32'hFFFF_FFFE);

        // R9 write-one-to-clear
        rd(1, v); chk("R9 status before", v, 32'h1C);
        wr(1, 32'h08);
        rd(1, v); chk("R9 clear one bit", v, 32'h14);
        wr(1, 0);
        rd(1, v); chk("R9 zero write no effect", v, 32'h14);
        wr(a_intv(5), 0);
        wr(a_cur(5), 0);
        wr(a_ctrl(5), mk_ctrl(0, 0, 1, 1));
        ticks(1);
        rd(1, v); chk("R9 ch5 pending", v & 32'h20, 32'h20);
        @(negedge clk);
        tick = 1'b1; wr_en = 1'b1; addr = AW'(1); wdata = 32'h20;
        @(negedge clk);
        tick = 1'b0; wr_en = 1'b0;
        rd(1, v); chk("R9 expiry beats clear", v & 32'h20, 32'h20);
        wr(a_ctrl(5), 0);
        wr(1, 32'h20);
        rd(1, v); chk("R9 cleared after stop", v, 32'h14);

        // R10 interrupt masking
        #1; chk("R10 irq masked", 32'(irq), 0);
        wr(0, 32'h08);
        #1; chk("R10 enable without pending", 32'(irq), 0);
        wr(0, 32'h04);
        #1; chk("R10 enabled pending", 32'(irq), 1);
        wr(1, 32'h04);
        #1; chk("R10 cleared drops irq", 32'(irq), 0);
        wr(0, 0);

        // R11 independence
        wr(1, 32'h3F);
        wr(a_cur(1), 77);
        wr(a_cur(0), 100);
        wr(a_ctrl(0), mk_ctrl(0, 0, 0, 1));
        ticks(5);
        wr(a_ctrl(0), 0);
        rd(a_cur(0), v); chk("R11 ch0 counted", v, 95);
        rd(a_cur(1), v); chk("R11 ch1 untouched", v, 77);
        rd(a_intv(3), v); chk("R11 ch3 interval untouched", v, 4);
        rd(1, v); chk("R11 no stray pending", v, 0);

        // random reload runs, R4 R5 R7
        for (int it = 0; it < 24; it++) begin
            int c, n, iv, p, s, ex;
            c  = int'($urandom % NCH);
            n  = int'($urandom % 20);
            iv = int'($urandom % 10);
            p  = int'($urandom % 8);
            s  = int'($urandom % 30);
            ex = int'($urandom % (p + 1));
            wr(1, 32'h3F);
            wr(a_intv(c), 32'(iv));
            wr(a_cur(c), 32'(n));
            wr(a_ctrl(c), mk_ctrl(0, p, 1, 1));
            if (s * (p + 1) + ex > 0) ticks(s * (p + 1) + ex);
            wr(a_ctrl(c), 0);
            rd(a_cur(c), v); chk("R7 random reload count", v, exp_reload(n, iv, s));
            rd(1, v); chk("R5 random pending", 32'(v[c]), (s > n) ? 1 : 0);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule